// File: doc/BRIEF.md
# Asynchronous Static RAM Word-Access Controller

This block sits between an on-chip valid/ready request port and an external asynchronous static RAM of 2M words by 16 bits with one shared bidirectional data bus. Each accepted request is a single-word read or write with a two-bit lane mask. The controller turns it into a timed sequence on the RAM pins: address, active-low chip select, output enable, write strobe and two active-low lane enables. It hands the pad level a separate outbound data word, an inbound data word and a drive enable, so the tristate pad sits outside the block.

Every analogue interval (strobe width, data setup, bus float after the strobe falls, access time, read cycle time, power-up wait) is a parameter in picoseconds. Each is turned into a count of clock cycles by rounding up, with a floor of one cycle. After reset the port stays closed until the power-up wait has run out. Only one request is in flight at a time. A read returns its word through a one-cycle response pulse, with the lanes that were not selected forced to zero.

The control is one state machine. The states are `ST_PWRUP`, `ST_IDLE`, `ST_WR_FLOAT`, `ST_WR_DRIVE`, `ST_WR_HOLD` and `ST_RD_ACCESS`. Its transitions are:
- power-up wait done: `ST_PWRUP` to `ST_IDLE`.
- write accepted: `ST_IDLE` to `ST_WR_FLOAT`.
- float time done: `ST_WR_FLOAT` to `ST_WR_DRIVE`.
- setup and strobe time done: `ST_WR_DRIVE` to `ST_WR_HOLD`.
- hold cycle: `ST_WR_HOLD` to `ST_IDLE`.
- read accepted: `ST_IDLE` to `ST_RD_ACCESS`.
- access time done, with the word captured: `ST_RD_ACCESS` to `ST_IDLE`.

Top module: `asram_ctrl`

## Requirements
- R1: For N_PU = ceil(T_PWRUP / period) cycles after reset is released, req_ready is 0 and all strobes (chip select, output enable, write strobe, both lane enables) are high. req_ready first reads 1 in cycle N_PU.
- R2: Outside an access the RAM is deselected. Chip select, output enable, write strobe and both lane enables are high, and dq_oe is 0 except in the single hold cycle that ends a write.
- R3: A write holds chip select and write strobe low, with output enable high, for N_HZ + N_WD consecutive cycles, starting the cycle after acceptance. N_HZ = ceil(float time), and N_WD = max(ceil(data setup), ceil(strobe width) - N_HZ, 1). sram_addr carries the request address, unchanged, for as long as chip select is low.
- R4: During a write, dq_oe stays 0 for the first N_HZ strobe-low cycles. It is then 1 for the last N_WD strobe-low cycles and for one more cycle after the strobe rises, with chip select already high. dq_out equals the request data whenever dq_oe is 1.
- R5: During a write, the low lane enable (bits 7:0) is the inverse of req_mask[0] and the high lane enable (bits 15:8) is the inverse of req_mask[1]. Only lanes whose mask bit is 1 change in the RAM, and a mask of 00 changes nothing.
- R6: A read holds chip select and output enable low, with write strobe high and dq_oe 0, for N_RD = max(ceil(cycle time), ceil(address access), ceil(output-enable access)) cycles, starting the cycle after acceptance. The lane enables follow req_mask as in R5, and sram_addr is steady.
- R7: A read ends with rsp_valid high for exactly one cycle, the cycle after chip select rises. rsp_rdata holds the bus word sampled at the clock edge that ends the last access cycle, with each lane whose mask bit is 0 forced to zero.
- R8: req_ready is 1 only in idle. It drops the cycle after a request is accepted and returns only once the previous access has fully finished.
- R9: dq_oe is never 1 while output enable is low. Between the last driven cycle of a write and the first output-enable-low cycle of a following read there is at least one full cycle with dq_oe 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 21 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 0 = bits 7:0, bit 1 = bits 15:8, 1 = lane used |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 21 | RAM address pins |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_lb_n | output | 1 | Low lane enable, active low |
| sram_ub_n | output | 1 | High lane enable, active low |
| dq_out | output | 16 | Data toward the pad |
| dq_in | input | 16 | Data from the pad |
| dq_oe | output | 1 | Pad drive enable |

## Verification
The bench tries the controller with:
- a request held during the power-up wait, which shows whether the gate opens in the right cycle.
- every lane mask on both reads and writes, including a write with an empty mask, which separates lane steering from plain data passing.
- writes followed at once by reads, which expose a missing turnaround cycle.
- back-to-back reads and back-to-back writes, which expose a ready signal that returns too early.

The RAM model puts a poison word on the bus until the access time has elapsed, so a read sampled one cycle early is told apart from a correct one. Addresses at zero and at the top of the space check that the address path is full width.

// File: rtl/asram_pkg.sv
package asram_pkg;

    typedef enum logic [2:0] {
        ST_PWRUP,
        ST_IDLE,
        ST_WR_FLOAT,
        ST_WR_DRIVE,
        ST_WR_HOLD,
        ST_RD_ACCESS
    } asram_state_e;

    // Round a time up to whole clock cycles, never fewer than one.
    function automatic int unsigned cycles_for(input int unsigned t_ps, input int unsigned clk_ps);
        int unsigned c;
        c = (t_ps + clk_ps - 1) / clk_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_pwrup_gate.sv
module asram_pwrup_gate #(
    parameter int unsigned N_PU = 10000
) (
    input  logic clk,
    input  logic rst_n,
    output logic open_o
);
    localparam int unsigned CW = $clog2(N_PU + 1);
    localparam logic [CW-1:0] LAST = CW'(N_PU - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign open_o = (cnt == LAST);
endmodule

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         done
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);
endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned ADDR_W        = 21,
    parameter int unsigned DATA_W        = 16,
    parameter int unsigned CLK_PERIOD_PS = 10000,
    parameter int unsigned T_WP_PS       = 9000,
    parameter int unsigned T_DS_PS       = 7000,
    parameter int unsigned T_HZWE_PS     = 7000,
    parameter int unsigned T_RC_PS       = 12000,
    parameter int unsigned T_AA_PS       = 12000,
    parameter int unsigned T_DOE_PS      = 7000,
    parameter int unsigned T_PWRUP_PS    = 100000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [1:0]        req_mask,
    output logic              rsp_valid,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n,
    output logic [DATA_W-1:0] dq_out,
    input  logic [DATA_W-1:0] dq_in,
    output logic              dq_oe
);
    localparam int unsigned LANE_W = DATA_W / 2;
    localparam int unsigned N_HZ   = cycles_for(T_HZWE_PS, CLK_PERIOD_PS);
    localparam int unsigned N_DS   = cycles_for(T_DS_PS, CLK_PERIOD_PS);
    localparam int unsigned N_WP   = cycles_for(T_WP_PS, CLK_PERIOD_PS);
    localparam int unsigned N_WD   = max2(max2(N_DS, (N_WP > N_HZ) ? (N_WP - N_HZ) : 1), 1);
    localparam int unsigned N_RD   = max2(max2(cycles_for(T_RC_PS, CLK_PERIOD_PS),
                                               cycles_for(T_AA_PS, CLK_PERIOD_PS)),
                                          cycles_for(T_DOE_PS, CLK_PERIOD_PS));
    localparam int unsigned N_PU   = cycles_for(T_PWRUP_PS, CLK_PERIOD_PS);
    localparam int unsigned N_MAX  = max2(max2(N_HZ, N_WD), N_RD);
    localparam int unsigned TW     = $clog2(N_MAX + 1);

    asram_state_e state, state_nxt;
    logic          gate_open;
    logic          ph_load;
    logic [TW-1:0] ph_val;
    logic          ph_done;
    logic [1:0]    hold_mask;
    logic          accept;
    logic [1:0]    sel_mask;
    logic          nxt_sel, nxt_wr_strobe, nxt_rd, nxt_drive;

    asram_pwrup_gate #(.N_PU(N_PU)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .open_o (gate_open)
    );

    asram_phase_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ph_load),
        .load_val (ph_val),
        .done     (ph_done)
    );

    assign req_ready = (state == ST_IDLE);
    assign accept    = req_ready && req_valid;
    assign sel_mask  = accept ? req_mask : hold_mask;

    // Next-state logic and phase timer loading
    always_comb begin
        state_nxt = state;
        ph_load   = 1'b0;
        ph_val    = '0;
        unique case (state)
            ST_PWRUP: begin
                if (gate_open) state_nxt = ST_IDLE;
            end
            ST_IDLE: begin
                if (req_valid) begin
                    ph_load = 1'b1;
                    if (req_write) begin
                        state_nxt = ST_WR_FLOAT;
                        ph_val    = TW'(N_HZ - 1);
                    end else begin
                        state_nxt = ST_RD_ACCESS;
                        ph_val    = TW'(N_RD - 1);
                    end
                end
            end
            ST_WR_FLOAT: begin
                if (ph_done) begin
                    state_nxt = ST_WR_DRIVE;
                    ph_load   = 1'b1;
                    ph_val    = TW'(N_WD - 1);
                end
            end
            ST_WR_DRIVE: begin
                if (ph_done) state_nxt = ST_WR_HOLD;
            end
            ST_WR_HOLD: begin
                state_nxt = ST_IDLE;
            end
            ST_RD_ACCESS: begin
                if (ph_done) state_nxt = ST_IDLE;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_PWRUP;
        else        state <= state_nxt;
    end

    assign nxt_wr_strobe = (state_nxt == ST_WR_FLOAT) || (state_nxt == ST_WR_DRIVE);
    assign nxt_rd        = (state_nxt == ST_RD_ACCESS);
    assign nxt_sel       = nxt_wr_strobe || nxt_rd;
    assign nxt_drive     = (state_nxt == ST_WR_DRIVE) || (state_nxt == ST_WR_HOLD);

    // Registered pin and response outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sram_addr <= '0;
            dq_out    <= '0;
            hold_mask <= '0;
            sram_ce_n <= 1'b1;
            sram_oe_n <= 1'b1;
            sram_we_n <= 1'b1;
            sram_lb_n <= 1'b1;
            sram_ub_n <= 1'b1;
            dq_oe     <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            if (accept) begin
                sram_addr <= req_addr;
                dq_out    <= req_wdata;
                hold_mask <= req_mask;
            end
            sram_ce_n <= !nxt_sel;
            sram_we_n <= !nxt_wr_strobe;
            sram_oe_n <= !nxt_rd;
            sram_lb_n <= nxt_sel ? !sel_mask[0] : 1'b1;
            sram_ub_n <= nxt_sel ? !sel_mask[1] : 1'b1;
            dq_oe     <= nxt_drive;
            rsp_valid <= (state == ST_RD_ACCESS) && ph_done;
            if ((state == ST_RD_ACCESS) && ph_done) begin
                rsp_rdata <= dq_in & {{LANE_W{hold_mask[1]}}, {LANE_W{hold_mask[0]}}};
            end
        end
    end
endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
    parameter int unsigned ADDR_W = 21,
    parameter int unsigned N_PU   = 10000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              dq_oe,
    input logic              rsp_valid
);
    int unsigned since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               since_rst <= 0;
        else if (since_rst < N_PU) since_rst <= since_rst + 1;
    end

    // R1
    pwrup_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (since_rst >= N_PU));

    // R2
    deselect_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sram_ce_n |-> (sram_we_n && sram_oe_n));

    // R3
    write_no_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    // R3
    addr_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

    // R6
    read_no_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n && !dq_oe));

    // R7
    rsp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R7
    rsp_after_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(!sram_oe_n) && sram_ce_n));

    // R8
    one_in_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9
    turnaround_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_oe_n) |-> $past(!dq_oe));
endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .N_PU(N_PU)) u_asram_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .sram_ce_n (sram_ce_n),
    .sram_oe_n (sram_oe_n),
    .sram_we_n (sram_we_n),
    .sram_addr (sram_addr),
    .dq_oe     (dq_oe),
    .rsp_valid (rsp_valid)
);

// File: tb/asram_ctrl_bench.sv
`timescale 1ns/1ps
module asram_ctrl_bench;
    localparam int CLK_PS   = 10000;
    localparam int WP_PS    = 35000;
    localparam int DS_PS    = 7000;
    localparam int HZ_PS    = 7000;
    localparam int RC_PS    = 12000;
    localparam int AA_PS    = 12000;
    localparam int DOE_PS   = 7000;
    localparam int PU_PS    = 20000000;

    // Expected cycle counts, rounded up, at least one
    localparam int B_HZ  = ((HZ_PS + CLK_PS - 1) / CLK_PS) < 1 ? 1 : ((HZ_PS + CLK_PS - 1) / CLK_PS);
    localparam int B_DS  = (DS_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_WP  = (WP_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_WD0 = (B_WP - B_HZ) > B_DS ? (B_WP - B_HZ) : B_DS;
    localparam int B_WD  = B_WD0 < 1 ? 1 : B_WD0;
    localparam int B_RC  = (RC_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_AA  = (AA_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_DOE = (DOE_PS + CLK_PS - 1) / CLK_PS;
    localparam int B_RD  = (B_RC > B_AA ? B_RC : B_AA) > B_DOE ? (B_RC > B_AA ? B_RC : B_AA) : B_DOE;
    localparam int B_PU  = (PU_PS + CLK_PS - 1) / CLK_PS;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [20:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [20:0] sram_addr;
    logic        sram_ce_n, sram_oe_n, sram_we_n, sram_lb_n, sram_ub_n;
    logic [15:0] dq_out;
    logic [15:0] dq_in;
    logic        dq_oe;

    always #5 clk = ~clk;

    asram_ctrl #(
        .CLK_PERIOD_PS (CLK_PS), .T_WP_PS (WP_PS), .T_DS_PS (DS_PS), .T_HZWE_PS (HZ_PS),
        .T_RC_PS (RC_PS), .T_AA_PS (AA_PS), .T_DOE_PS (DOE_PS), .T_PWRUP_PS (PU_PS)
    ) u_asram_ctrl (
        .clk (clk), .rst_n (rst_n),
        .req_valid (req_valid), .req_ready (req_ready), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .req_mask (req_mask),
        .rsp_valid (rsp_valid), .rsp_rdata (rsp_rdata),
        .sram_addr (sram_addr), .sram_ce_n (sram_ce_n), .sram_oe_n (sram_oe_n),
        .sram_we_n (sram_we_n), .sram_lb_n (sram_lb_n), .sram_ub_n (sram_ub_n),
        .dq_out (dq_out), .dq_in (dq_in), .dq_oe (dq_oe)
    );

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s act=%h exp=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] dflt_word(input logic [20:0] a);
        return a[15:0] ^ 16'hA55A;
    endfunction

    function automatic logic [15:0] lanes(input logic [1:0] m);
        return {{8{m[1]}}, {8{m[0]}}};
    endfunction

    // ---------------- RAM device model ----------------
    logic [15:0] dev_mem [logic [20:0]];
    logic [15:0] dev_q = '0;
    int          rd_age = 0;
    wire         rd_pins = !sram_ce_n && !sram_oe_n && sram_we_n;

    always @(posedge clk) begin
        if (!sram_ce_n && !sram_we_n && dq_oe) begin
            logic [15:0] cur;
            cur = dev_mem.exists(sram_addr) ? dev_mem[sram_addr] : dflt_word(sram_addr);
            if (!sram_lb_n) cur[7:0]  = dq_out[7:0];
            if (!sram_ub_n) cur[15:8] = dq_out[15:8];
            dev_mem[sram_addr] = cur;
        end
        dev_q  <= dev_mem.exists(sram_addr) ? dev_mem[sram_addr] : dflt_word(sram_addr);
        rd_age <= rd_pins ? rd_age + 1 : 0;
    end

    // Poison word until the access time has elapsed
    assign dq_in = (rd_pins && rd_age >= B_RD - 1) ? dev_q : 16'hBAD0;

    // ---------------- Reference model ----------------
    typedef struct {
        bit          rdy;
        bit          ce_n;
        bit          oe_n;
        bit          we_n;
        bit [1:0]    lane_n;
        bit          drv;
        bit          rsp;
        logic [20:0] addr;
        logic [15:0] data;
        string       tag;
        string       ltag;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    logic [15:0] gold [logic [20:0]];
    int          pu_left = B_PU;
    bit          acc_flag = 1'b0;
    int          cycles = 0;
    int          gap = 0;
    bit          had_write = 1'b0;
    bit          prev_oe_n = 1'b1;
    bit          done_all = 1'b0;

    function automatic exp_t mk(bit rdy, bit ce_n, bit oe_n, bit we_n, bit [1:0] ln, bit drv, bit rsp,
                                logic [20:0] a, logic [15:0] d, string tag, string ltag);
        exp_t e;
        e.rdy = rdy; e.ce_n = ce_n; e.oe_n = oe_n; e.we_n = we_n; e.lane_n = ln;
        e.drv = drv; e.rsp = rsp; e.addr = a; e.data = d; e.tag = tag; e.ltag = ltag;
        return e;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            pu_left = B_PU;
            q.delete();
        end else begin
            if (pu_left > 0) pu_left--;
            if (cur.rdy && req_valid) begin
                acc_flag = 1'b1;
                if (req_write) begin
                    logic [15:0] g;
                    g = gold.exists(req_addr) ? gold[req_addr] : dflt_word(req_addr);
                    g = (g & ~lanes(req_mask)) | (req_wdata & lanes(req_mask));
                    gold[req_addr] = g;
                    for (int i = 0; i < B_HZ; i++)
                        q.push_back(mk(0, 0, 1, 0, ~req_mask, 0, 0, req_addr, req_wdata, "R3", "R5"));
                    for (int i = 0; i < B_WD; i++)
                        q.push_back(mk(0, 0, 1, 0, ~req_mask, 1, 0, req_addr, req_wdata, "R4", "R5"));
                    q.push_back(mk(0, 1, 1, 1, 2'b11, 1, 0, req_addr, req_wdata, "R4", "R2"));
                end else begin
                    logic [15:0] g;
                    g = gold.exists(req_addr) ? gold[req_addr] : dflt_word(req_addr);
                    for (int i = 0; i < B_RD; i++)
                        q.push_back(mk(0, 0, 0, 1, ~req_mask, 0, 0, req_addr, '0, "R6", "R6"));
                    q.push_back(mk(1, 1, 1, 1, 2'b11, 0, 1, req_addr, g & lanes(req_mask), "R7", "R2"));
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done_all) begin
            cycles++;
            if (!rst_n || pu_left > 0)
                cur = mk(0, 1, 1, 1, 2'b11, 0, 0, '0, '0, "R1", "R1");
            else if (q.size() > 0)
                cur = q.pop_front();
            else
                cur = mk(1, 1, 1, 1, 2'b11, 0, 0, '0, '0, "R2", "R2");
            chk(cur.tag, "ready", 32'(req_ready), 32'(cur.rdy));
            chk(cur.tag, "ce/oe/we", 32'({sram_ce_n, sram_oe_n, sram_we_n}),
                32'({cur.ce_n, cur.oe_n, cur.we_n}));
            chk(cur.tag, "dq_oe", 32'(dq_oe), 32'(cur.drv));
            chk(cur.tag, "rsp_valid", 32'(rsp_valid), 32'(cur.rsp));
            chk(cur.ltag, "lanes", 32'({sram_ub_n, sram_lb_n}), 32'(cur.lane_n));
            if (!cur.ce_n) chk(cur.tag, "addr", 32'(sram_addr), 32'(cur.addr));
            if (cur.drv)   chk("R4", "dq_out", 32'(dq_out), 32'(cur.data));
            if (cur.rsp)   chk("R7", "rsp_rdata", 32'(rsp_rdata), 32'(cur.data));
            // R9: idle drive gap before a read that follows a write
            if (dq_oe) begin gap = 0; had_write = 1'b1; end
            else if (gap < 100) gap++;
            if (!sram_oe_n && prev_oe_n && had_write) begin
                chk("R9", "turnaround gap", 32'(gap >= 2), 32'd1);
                had_write = 1'b0;
            end
            if (!sram_oe_n) had_write = 1'b0;
            prev_oe_n = sram_oe_n;
            if (dq_oe && !sram_oe_n) chk("R9", "bus fight", 32'd1, 32'd0);
        end
    end

    // ---------------- Stimulus ----------------
    task automatic do_req(input bit wr, input logic [20:0] a, input logic [15:0] d,
                          input logic [1:0] m, input int idle_after);
        req_write = wr; req_addr = a; req_wdata = d; req_mask = m; req_valid = 1'b1;
        do @(negedge clk); while (!acc_flag);
        acc_flag  = 1'b0;
        req_valid = 1'b0;
        repeat (idle_after) @(negedge clk);
    endtask

    initial begin : watchdog
        repeat (150000) @(negedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired act=%0d exp<150000", cycles);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: request held through the power-up wait
        do_req(1, 21'h000010, 16'h1234, 2'b11, 0);
        // R9: read right after a write
        do_req(0, 21'h000010, 16'h0000, 2'b11, 2);
        // R5: low lane only, then high lane only
        do_req(1, 21'h000010, 16'hABCD, 2'b01, 0);
        do_req(0, 21'h000010, 16'h0000, 2'b11, 1);
        do_req(1, 21'h000010, 16'h5678, 2'b10, 3);
        do_req(0, 21'h000010, 16'h0000, 2'b10, 0);
        do_req(0, 21'h000010, 16'h0000, 2'b01, 0);
        // R5: empty mask changes nothing
        do_req(1, 21'h000010, 16'h0000, 2'b00, 0);
        do_req(0, 21'h000010, 16'h0000, 2'b11, 1);
        // Address extremes and an unwritten word
        do_req(1, 21'h1FFFFF, 16'h0F0F, 2'b11, 0);
        do_req(1, 21'h000000, 16'hF00F, 2'b11, 0);
        do_req(0, 21'h1FFFFF, 16'h0000, 2'b11, 0);
        do_req(0, 21'h000000, 16'h0000, 2'b11, 0);
        do_req(0, 21'h0AAAAA, 16'h0000, 2'b11, 0);
        // R8: read pressure and write pressure
        for (int i = 0; i < 8; i++)
            do_req(i[0], 21'h100 + 21'(i >> 1), 16'h3C00 + 16'(i), 2'(i % 3 + 1), i % 2);
        for (int i = 0; i < 4; i++)
            do_req(0, 21'h100 + 21'(i), 16'h0000, 2'b11, 0);
        wait (q.size() == 0);
        repeat (5) @(negedge clk);
        done_all = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule